// File: doc/BRIEF.md
# Overflow Event Timer

This block is a free-running up-counter that raises an interrupt when it steps past its all-ones value. Software controls it over a small synchronous register bus. A delay of N cycles is set by loading the counter with all-ones minus N. The counter then crosses all-ones N+1 clocks later, and at that edge an overflow flag is set.

There are two operating styles. In one-shot mode the counter stops by itself after the overflow. In periodic mode every overflow reloads the counter from a separate reload register and counting goes on, so a tick of period P comes from a reload value of all-ones minus (P-1).

Loading the reload value and starting the counter are separate bus writes. A dedicated "go" address writes the counter and sets the run bit in the same operation. Software can halt the counter by clearing the run bit, read the value that is held, and later resume from it.

Top module: `ovt_timer`

## Requirements
- R1: After reset, every readable register reads zero and `irq` is low.
- R2: While the run bit (control bit 0) is set and no counter write occurs, the counter rises by exactly one every clock.
- R3: A write to the go address (index 3) loads the counter with the written value and sets the run bit. After loading all-ones minus N, the overflow flag (status bit 0, address index 4) is set at the clock edge N+1 cycles after the load.
- R4: With the auto-reload bit (control bit 1) set, an overflow loads the counter from the reload register (index 1) and the run bit stays set.
- R5: With the auto-reload bit clear, an overflow clears the run bit and leaves the counter at zero, where it holds.
- R6: Writing 1 to status bit 0 clears the overflow flag. Writing 0 there leaves the flag unchanged.
- R7: If an overflow and a clearing write to the status register happen in the same cycle, the flag ends set.
- R8: `irq` is high exactly when the overflow flag is set and the interrupt-enable bit (control bit 2) is set. It is a level, not a pulse.
- R9: Writing the control register (index 0) with the run bit clear halts the counter and holds its value. A write to the counter address (index 2) changes the value without starting it, and a later go write resumes counting.
- R10: A bus write to the counter or go address takes priority over the increment in that cycle. Reads of both addresses return the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, combinational from the address |
| irq | output | 1 | Level interrupt: overflow flag AND enable |

## Verification
Read data is combinational, so a read returns, in the same cycle, the state left by the previous edge. A write takes effect at the next rising edge. The overflow lands N+1 edges after a go write of all-ones minus N, and `irq` follows the flag with no added delay. The bench drives every access on the falling edge and samples one nanosecond later. A requirement-level model advances at each rising edge, so every expected value is due at the first falling edge after the edge that produces it. The directed sequences count reads exactly: a clearing write is placed so that it lands on the overflow edge itself.

// File: rtl/ovt_pkg.sv
package ovt_pkg;
   // register word indices (bus_addr values)
   localparam int unsigned REG_CTRL   = 0;
   localparam int unsigned REG_RELOAD = 1;
   localparam int unsigned REG_COUNT  = 2;
   localparam int unsigned REG_GO     = 3;
   localparam int unsigned REG_STATUS = 4;
   localparam int unsigned NUM_REGS   = 5;

   // control word layout: bit0 run, bit1 auto-reload, bit2 irq enable
   typedef struct packed {
      logic ien;
      logic auto_rl;
      logic run;
   } ctrl_t;
   localparam int unsigned CTRL_BITS = $bits(ctrl_t);
endpackage

// File: rtl/ovt_counter.sv
module ovt_counter #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         auto_rl,
   input  logic [W-1:0] reload,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] count,
   output logic         ovf
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] count_d;

   // overflow is the step taken from all-ones while running
   assign ovf = run && (&count);

   always_comb begin
      if (load)
         count_d = load_val;
      else if (ovf)
         count_d = auto_rl ? reload : '0;
      else if (run)
         count_d = count + ONE;
      else
         count_d = count;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= count_d;
   end
endmodule

// File: rtl/ovt_regs.sv
module ovt_regs
   import ovt_pkg::*;
#(
   parameter int unsigned W      = 32,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [W-1:0]      bus_wdata,
   input  logic [W-1:0]      count,
   input  logic              ovf,
   output ctrl_t             ctrl,
   output logic [W-1:0]      reload,
   output logic              flag,
   output logic              cnt_load,
   output logic [W-1:0]      bus_rdata
);
   logic [NUM_REGS-1:0] wr_hit;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
      assign wr_hit[i] = bus_sel && bus_we && (bus_addr == ADDR_W'(i));
   end

   assign cnt_load = wr_hit[REG_COUNT] || wr_hit[REG_GO];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr_hit[REG_CTRL]) begin
         ctrl <= ctrl_t'(bus_wdata[CTRL_BITS-1:0]);
      end else if (wr_hit[REG_GO]) begin
         ctrl.run <= 1'b1;
      end else if (ovf && !ctrl.auto_rl) begin
         ctrl.run <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  reload <= '0;
      else if (wr_hit[REG_RELOAD]) reload <= bus_wdata;
   end

   // a new overflow outranks a clearing write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  flag <= 1'b0;
      else if (ovf)                                flag <= 1'b1;
      else if (wr_hit[REG_STATUS] && bus_wdata[0]) flag <= 1'b0;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(REG_CTRL))
         bus_rdata = W'(ctrl);
      else if (bus_addr == ADDR_W'(REG_RELOAD))
         bus_rdata = reload;
      else if (bus_addr == ADDR_W'(REG_COUNT) || bus_addr == ADDR_W'(REG_GO))
         bus_rdata = count;
      else if (bus_addr == ADDR_W'(REG_STATUS))
         bus_rdata = W'(flag);
   end
endmodule

// File: rtl/ovt_timer.sv
module ovt_timer
   import ovt_pkg::*;
#(
   parameter int unsigned W      = 32,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [W-1:0]      bus_wdata,
   output logic [W-1:0]      bus_rdata,
   output logic              irq
);
   if (W < 8 || W > 64) begin : g_bad_width
      $error("ovt_timer: W must lie in 8..64");
   end
   if ((2 ** ADDR_W) < NUM_REGS) begin : g_bad_addr
      $error("ovt_timer: ADDR_W too narrow for the register set");
   end

   ctrl_t        ctrl_q;
   logic [W-1:0] reload_q;
   logic [W-1:0] count_q;
   logic         flag_q;
   logic         ovf;
   logic         cnt_load;

   ovt_regs #(.W(W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .count     (count_q),
      .ovf       (ovf),
      .ctrl      (ctrl_q),
      .reload    (reload_q),
      .flag      (flag_q),
      .cnt_load  (cnt_load),
      .bus_rdata (bus_rdata)
   );

   ovt_counter #(.W(W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl_q.run),
      .auto_rl  (ctrl_q.auto_rl),
      .reload   (reload_q),
      .load     (cnt_load),
      .load_val (bus_wdata),
      .count    (count_q),
      .ovf      (ovf)
   );

   assign irq = flag_q && ctrl_q.ien;
endmodule

// File: rtl/ovt_timer_chk.sv
module ovt_timer_chk
   import ovt_pkg::*;
#(
   parameter int unsigned W      = 32,
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [W-1:0]      bus_wdata,
   input logic [W-1:0]      count,
   input logic [W-1:0]      reload,
   input logic              run,
   input logic              auto_rl,
   input logic              flag
);
   logic any_wr, cnt_wr, st_clr, at_top;
   assign any_wr = bus_sel && bus_we;
   assign cnt_wr = any_wr && (bus_addr == ADDR_W'(REG_COUNT) || bus_addr == ADDR_W'(REG_GO));
   assign st_clr = any_wr && (bus_addr == ADDR_W'(REG_STATUS)) && bus_wdata[0];
   assign at_top = run && (&count);

   assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !(&count) && !cnt_wr) |=> (count == $past(count) + W'(1)));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> $stable(count));

   assert_ovf_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      at_top |=> flag);

   assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (at_top && auto_rl && !any_wr) |=> (run && count == $past(reload)));

   assert_oneshot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (at_top && !auto_rl && !any_wr) |=> (!run && count == '0));

   assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && st_clr && !at_top) |=> !flag);
endmodule

bind ovt_timer ovt_timer_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .count     (count_q),
   .reload    (reload_q),
   .run       (ctrl_q.run),
   .auto_rl   (ctrl_q.auto_rl),
   .flag      (flag_q)
);

// File: tb/test_ovt_timer.sv
`timescale 1ns/1ps
module test_ovt_timer;
   localparam logic [31:0] ONES = 32'hFFFF_FFFF;
   localparam logic [2:0] A_CTRL = 3'd0, A_REL = 3'd1, A_CNT = 3'd2, A_GO = 3'd3, A_ST = 3'd4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_sel = 1'b0, bus_we = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic irq;

   int checks = 0, errs = 0;
   logic [31:0] rd;

   // requirement model state
   logic [31:0] m_cnt = '0, m_rel = '0;
   logic m_run = 0, m_ar = 0, m_ie = 0, m_flag = 0;

   always #10 clk = ~clk;

   ovt_timer #(.W(32), .ADDR_W(3)) i_ovt_timer (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   always @(posedge clk) begin
      logic ovf, wr;
      if (!rst_n) begin
         m_cnt = '0; m_rel = '0; m_run = 0; m_ar = 0; m_ie = 0; m_flag = 0;
      end else begin
         wr  = bus_sel && bus_we;
         ovf = m_run && (m_cnt == ONES);
         if (ovf) m_flag = 1;                                      // R3 R7
         else if (wr && bus_addr == A_ST && bus_wdata[0]) m_flag = 0; // R6
         if (ovf) begin
            if (m_ar) m_cnt = m_rel;                               // R4
            else begin m_cnt = '0; m_run = 0; end                  // R5
         end else if (m_run) m_cnt = m_cnt + 1;                    // R2
         if (wr) begin
            case (bus_addr)
               A_CTRL: begin m_run = bus_wdata[0]; m_ar = bus_wdata[1]; m_ie = bus_wdata[2]; end
               A_REL:  m_rel = bus_wdata;
               A_CNT:  m_cnt = bus_wdata;                          // R10
               A_GO:   begin m_cnt = bus_wdata; m_run = 1; end
               default: ;
            endcase
         end
      end
   end

   function automatic logic [31:0] m_read(input logic [2:0] a);
      case (a)
         A_CTRL:     return {29'b0, m_ie, m_ar, m_run};
         A_REL:      return m_rel;
         A_CNT, A_GO: return m_cnt;
         A_ST:       return {31'b0, m_flag};
         default:    return '0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errs++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic cycle(input logic s, input logic w, input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
      #1;
      chk("R8 irq level", {31'b0, irq}, {31'b0, m_flag && m_ie});
      if (s && !w) begin
         rd = bus_rdata;
         case (a)
            A_CNT, A_GO: chk("R2 count read", rd, m_read(a));
            A_REL:       chk("R4 reload read", rd, m_read(a));
            A_CTRL:      chk("R5 control read", rd, m_read(a));
            A_ST:        chk("R6 status read", rd, m_read(a));
            default:     chk("R1 unmapped read", rd, m_read(a));
         endcase
      end
   endtask

   task automatic rdr(input logic [2:0] a); cycle(1, 0, a, '0); endtask
   task automatic wrr(input logic [2:0] a, input logic [31:0] d); cycle(1, 1, a, d); endtask

   initial begin
      #4_000_000;
      errs++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [31:0] v1;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 5; a++) begin
         rdr(3'(a)); chk("R1 reset value", rd, 32'h0);
      end
      chk("R1 irq after reset", {31'b0, irq}, 32'h0);

      // R3 / R5: one-shot, N = 5, interrupt enabled
      wrr(A_CTRL, 32'h4);
      wrr(A_GO, ONES - 5);
      for (int i = 0; i < 6; i++) begin
         rdr(A_CNT); chk("R3 count before overflow", rd, ONES - 5 + 32'(i));
      end
      rdr(A_ST);   chk("R3 flag at N+1", rd, 32'h1);
      chk("R8 irq with enable", {31'b0, irq}, 32'h1);
      rdr(A_CNT);  chk("R5 count after one-shot", rd, 32'h0);
      rdr(A_CNT);  chk("R5 count held", rd, 32'h0);
      rdr(A_CTRL); chk("R5 run cleared", rd, 32'h4);

      // R6: write-one-to-clear
      wrr(A_ST, 32'h0);
      rdr(A_ST); chk("R6 zero write ignored", rd, 32'h1);
      wrr(A_ST, 32'h1);
      rdr(A_ST); chk("R6 flag cleared", rd, 32'h0);
      chk("R8 irq drops", {31'b0, irq}, 32'h0);

      // R4: periodic, P = 4, interrupt disabled
      wrr(A_REL, ONES - 3);
      wrr(A_CTRL, 32'h2);
      wrr(A_GO, ONES - 3);
      for (int i = 0; i < 8; i++) begin
         rdr(A_CNT); chk("R4 periodic sequence", rd, ONES - 3 + 32'(i % 4));
      end
      rdr(A_ST);   chk("R4 flag set by reload", rd, 32'h1);
      chk("R8 irq masked", {31'b0, irq}, 32'h0);
      rdr(A_CTRL); chk("R4 run stays set", rd, 32'h3);

      // R7: clear lands on the overflow edge
      for (int k = 0; k < 8; k++) begin
         rdr(A_CNT);
         if (rd == ONES - 1) break;
      end
      wrr(A_ST, 32'h1);
      rdr(A_ST); chk("R7 overflow beats clear", rd, 32'h1);
      wrr(A_ST, 32'h1);
      rdr(A_ST); chk("R6 clear off overflow", rd, 32'h0);

      // R9: halt, hold, modify, resume
      wrr(A_CTRL, 32'h0);
      rdr(A_CNT); v1 = rd;
      rdr(A_CNT); chk("R9 halted count holds", rd, v1);
      wrr(A_CNT, 32'd100);
      rdr(A_CNT); chk("R9 written while stopped", rd, 32'd100);
      rdr(A_CNT); chk("R9 write does not start", rd, 32'd100);
      wrr(A_GO, 32'd200);
      rdr(A_CNT); chk("R9 resumed", rd, 32'd200);
      rdr(A_CNT); chk("R9 counting", rd, 32'd201);

      // R10: write beats increment
      wrr(A_CNT, 32'd50);
      rdr(A_GO); chk("R10 write wins", rd, 32'd50);
      rdr(A_GO); chk("R10 continues", rd, 32'd51);

      // constrained random phase against the model
      for (int n = 0; n < 4000; n++) begin
         logic [2:0] a;
         logic [31:0] d;
         a = 3'($urandom % 6);
         d = $urandom;
         if ((a == A_CNT || a == A_GO || a == A_REL) && ($urandom % 4 != 0))
            d = ONES - ($urandom % 8);
         if (a == A_CTRL) d = {29'b0, 3'($urandom)};
         cycle($urandom % 3 != 0, $urandom % 4 == 0, a, d);
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule